// File: doc/BRIEF.md
# Two-Vector Scan Chain with Hold Stage

This block is a parameterised scan chain for at-speed two-pattern testing. Each scan flip-flop drives the logic under test through a level-sensitive hold latch. The latch can keep a first vector (V1) applied to the logic while a second vector (V2) is shifted into the flip-flops behind it. Because V2 is loaded independently of V1, any pair of vectors can be applied back to back. The pair does not have to be derived from V1 by a one-bit shift or by a functional capture.

A built-in sequencer runs one complete test after a `start` pulse. It shifts in V1 and releases it to the logic. It then shifts in V2 while the latches keep V1 applied, releases V2, and captures the response on the next clock edge. Finally it shifts the response out serially and raises `done`. Single-cycle strobes mark the points where V1 and V2 reach the logic, so the tester can change the primary inputs at the same moments. While the sequencer is idle, the chain follows the manual `test_ctl` (shift or parallel capture) and `hold_in` inputs. This allows scan access step by step.

Top module: `enh_scan_chain`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears every scan cell, the hold stage output, `busy`, `done` and both strobes. After reset, `scan_out` and `vec_out` read 0.
- R2: In scan mode, each clock edge moves `scan_in` into cell 0 and moves cell i into cell i+1. `scan_out` always shows cell N-1, so a vector V loaded MSB-first ends with cell i holding V[i].
- R3: In normal mode (idle with `test_ctl` low), each clock edge loads `resp_in` into the cells in parallel, with bit i going to cell i.
- R4: While idle, `hold_in` high freezes `vec_out` no matter how the cells change. `hold_in` low makes `vec_out` follow the cells with no clock delay.
- R5: After a `start` pulse that is seen at an edge in idle, `busy` is high from the next edge onward. The test then runs in this order: N load cycles for V1; one cycle with `apply_v1` high; N load cycles for V2; one cycle with `apply_v2` high; N unload cycles. The two strobes are never high together.
- R6: During the V2 load cycles, `vec_out` stays equal to V1 while the cells shift.
- R7: In the `apply_v2` cycle, `vec_out` equals V2. The response present on `resp_in` in that cycle is captured at the edge that ends it, one clock period after V2 is released.
- R8: During unload, `scan_out` first shows response bit N-1 and then steps down one bit per clock, so bit N-1-k appears after k shift edges.
- R9: `done` rises together with the fall of `busy` at the end of the unload. It stays high until the next accepted `start`, and it is never high while `busy` is high. A `start` seen while busy has no effect on the sequence.
- R10: While busy, `test_ctl` and `hold_in` have no effect on the loaded vectors, the applied vectors or the unloaded response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a two-vector test when idle |
| test_ctl | input | 1 | Idle mode select: 1 = shift, 0 = parallel capture |
| hold_in | input | 1 | Idle hold control: 1 = freeze hold stage |
| scan_in | input | 1 | Serial scan data input |
| resp_in | input | N | Parallel response from the logic under test |
| vec_out | output | N | Held vector driving the logic under test |
| scan_out | output | 1 | Serial scan data output (cell N-1) |
| busy | output | 1 | Sequencer is running a test |
| done | output | 1 | Last test has finished unloading |
| apply_v1 | output | 1 | V1 is being released to the logic this cycle |
| apply_v2 | output | 1 | V2 is being released to the logic this cycle |

## Verification
The assertions check several properties on every cycle. They check the serial path through the chain on each shift edge and the parallel load on each capture edge. They check that `vec_out` holds still across the V2 load, that the hold stage is transparent in the launch cycle, that the strobes are exclusive, and the handshake between `busy`, `start` and `done`. Other behaviour can only be shown by the bench's scenarios, because it depends on the tester's data. This covers whether the applied pair really is the V1 and V2 that were shifted in, whether the captured response belongs to V2 and leaves in the right order, and whether manual hold and mode inputs are ignored during a test.

// File: rtl/enh_scan_pkg.sv
`timescale 1ns/1ps
// enh_scan_pkg
// Shared types for the two-vector scan chain: sequencer states and the
// operation applied to the scan cells on each clock edge.
package enh_scan_pkg;

    // Sequencer phases, in the order a test walks through them.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD1  = 3'd1,
        ST_APPLY1 = 3'd2,
        ST_LOAD2  = 3'd3,
        ST_LAUNCH = 3'd4,
        ST_UNLOAD = 3'd5
    } seq_state_e;

    // Action of the scan cells at the next clock edge.
    typedef enum logic [1:0] {
        OP_KEEP    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2
    } cell_op_e;

endpackage

// File: rtl/esc_cell_chain.sv
`timescale 1ns/1ps
// esc_cell_chain
// Row of N scan flip-flops. On each edge the row either keeps its value,
// shifts serially (scan_in -> cell 0 -> ... -> cell N-1), or loads the
// parallel response. Assumes N >= 2.
module esc_cell_chain
    import enh_scan_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cell_op_e     op,
    input  logic         scan_in,
    input  logic [N-1:0] resp_in,
    output logic [N-1:0] cells,
    output logic         scan_out
);

    localparam int TOP = N - 1;

    // Update the scan cells according to the requested operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else begin
            case (op)
                OP_SHIFT:   cells <= {cells[TOP-1:0], scan_in};
                OP_CAPTURE: cells <= resp_in;
                default:    cells <= cells;
            endcase
        end
    end

    // Serial output is the last cell of the row.
    assign scan_out = cells[TOP];

endmodule

// File: rtl/esc_hold_bank.sv
`timescale 1ns/1ps
// esc_hold_bank
// One level-sensitive latch per scan cell. Transparent while hold is low,
// frozen while hold is high. Assumes the controller only raises hold on
// edges where the latch inputs do not change.
module esc_hold_bank #(
    parameter int N = 8
) (
    input  logic         rst_n,
    input  logic         hold,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;

        // Latch one cell value toward the logic under test.
        always_latch begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (!hold) begin
                bit_q <= d[i];
            end
        end

        assign q[i] = bit_q;
    end

endmodule

// File: rtl/esc_sequencer.sv
`timescale 1ns/1ps
// esc_sequencer
// Runs one two-vector test per accepted start: load V1, apply V1, load V2
// under hold, launch V2 with capture at the following edge, unload.
// While idle it passes the manual mode and hold controls through.
// Assumes N >= 2.
module esc_sequencer
    import enh_scan_pkg::*;
#(
    parameter int N = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       test_ctl,
    input  logic       hold_in,
    output seq_state_e state,
    output cell_op_e   op,
    output logic       hold,
    output logic       busy,
    output logic       done,
    output logic       apply_v1,
    output logic       apply_v2
);

    localparam int           CW   = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt;

    // Phase register, shift counter and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_LOAD1;
                        cnt   <= LAST;
                        done  <= 1'b0;
                    end
                end
                ST_LOAD1: begin
                    if (cnt == '0) state <= ST_APPLY1;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_APPLY1: begin
                    state <= ST_LOAD2;
                    cnt   <= LAST;
                end
                ST_LOAD2: begin
                    if (cnt == '0) state <= ST_LAUNCH;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_LAUNCH: begin
                    state <= ST_UNLOAD;
                    cnt   <= LAST;
                end
                ST_UNLOAD: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Cell operation and hold control for the current phase.
    always_comb begin
        op   = OP_SHIFT;
        hold = 1'b0;
        case (state)
            ST_IDLE: begin
                op   = test_ctl ? OP_SHIFT : OP_CAPTURE;
                hold = hold_in;
            end
            ST_APPLY1: op = OP_KEEP;
            ST_LOAD2:  hold = 1'b1;
            ST_LAUNCH: op = OP_CAPTURE;
            default:   op = OP_SHIFT;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign apply_v1 = (state == ST_APPLY1);
    assign apply_v2 = (state == ST_LAUNCH);

endmodule

// File: rtl/enh_scan_chain.sv
`timescale 1ns/1ps
// enh_scan_chain
// Scan chain whose cells reach the logic under test through hold latches,
// so two independent vectors can be applied on consecutive clock periods.
// Assumes the logic under test settles within one clock period.
module enh_scan_chain
    import enh_scan_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         test_ctl,
    input  logic         hold_in,
    input  logic         scan_in,
    input  logic [N-1:0] resp_in,
    output logic [N-1:0] vec_out,
    output logic         scan_out,
    output logic         busy,
    output logic         done,
    output logic         apply_v1,
    output logic         apply_v2
);

    seq_state_e   seq_state;
    cell_op_e     cell_op;
    logic         hold_ctl;
    logic [N-1:0] chain_q;

    esc_sequencer #(.N(N)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .test_ctl (test_ctl),
        .hold_in  (hold_in),
        .state    (seq_state),
        .op       (cell_op),
        .hold     (hold_ctl),
        .busy     (busy),
        .done     (done),
        .apply_v1 (apply_v1),
        .apply_v2 (apply_v2)
    );

    esc_cell_chain #(.N(N)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (cell_op),
        .scan_in  (scan_in),
        .resp_in  (resp_in),
        .cells    (chain_q),
        .scan_out (scan_out)
    );

    esc_hold_bank #(.N(N)) u_hold (
        .rst_n (rst_n),
        .hold  (hold_ctl),
        .d     (chain_q),
        .q     (vec_out)
    );

endmodule

// File: rtl/enh_scan_chain_chk.sv
`timescale 1ns/1ps
// enh_scan_chain_chk
// Property checker attached to enh_scan_chain through bind.
module enh_scan_chain_chk
    import enh_scan_pkg::*;
#(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         scan_in,
    input logic [N-1:0] resp_in,
    input logic [N-1:0] vec_out,
    input logic         scan_out,
    input logic         busy,
    input logic         done,
    input logic         apply_v1,
    input logic         apply_v2,
    input logic [N-1:0] cells,
    input cell_op_e     op,
    input seq_state_e   state
);

    // R2
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (cells[0] == $past(scan_in) && scan_out == $past(cells[N-2])));

    // R3
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CAPTURE) |=> (cells == $past(resp_in)));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({apply_v1, apply_v2}));

    // R5
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6
    v1_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD2 && $past(state) == ST_LOAD2) |-> $stable(vec_out));

    // R7
    launch_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply_v2 |-> (vec_out == cells));

    // R9
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind enh_scan_chain enh_scan_chain_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .scan_in  (scan_in),
    .resp_in  (resp_in),
    .vec_out  (vec_out),
    .scan_out (scan_out),
    .busy     (busy),
    .done     (done),
    .apply_v1 (apply_v1),
    .apply_v2 (apply_v2),
    .cells    (chain_q),
    .op       (cell_op),
    .state    (seq_state)
);

// File: tb/test_enh_scan_chain.sv
`timescale 1ns/1ps
// Bench for enh_scan_chain: table-driven two-vector tests, then directed
// checks of reset, manual shift, capture and hold.
module test_enh_scan_chain;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic         test_ctl;
    logic         hold_in;
    logic         scan_in;
    logic [N-1:0] resp_in;
    logic [N-1:0] vec_out;
    logic         scan_out;
    logic         busy;
    logic         done;
    logic         apply_v1;
    logic         apply_v2;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    // Logic under test model: rotate-left, xor self, xor constant.
    function automatic logic [N-1:0] lut_f(input logic [N-1:0] v);
        return {v[N-2:0], v[N-1]} ^ v ^ 8'h96;
    endfunction

    assign resp_in = lut_f(vec_out);

    enh_scan_chain #(.N(N)) i_enh_scan_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .test_ctl (test_ctl),
        .hold_in  (hold_in),
        .scan_in  (scan_in),
        .resp_in  (resp_in),
        .vec_out  (vec_out),
        .scan_out (scan_out),
        .busy     (busy),
        .done     (done),
        .apply_v1 (apply_v1),
        .apply_v2 (apply_v2)
    );

    // {V1, V2, expected response to V2}
    localparam logic [23:0] TAB [0:4] = '{
        24'h00FF96, 24'hFF0096, 24'hA55A78, 24'h3C3CD2, 24'h0FF087
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // One full sequencer-driven test; manual controls are toggled to show they are ignored.
    task automatic run_pair(input logic [N-1:0] v1, input logic [N-1:0] v2, input logic [N-1:0] exp);
        logic [N-1:0] got;
        logic         v1_ok;
        start = 1'b1;
        test_ctl = 1'b0;            // R10: ignored while busy
        hold_in  = 1'b1;
        step();
        start = 1'b0;
        check("R5 busy after start", busy, 1);
        check("R9 done cleared on start", done, 0);
        for (int k = 0; k < N; k++) begin
            scan_in = v1[N-1-k];
            step();
        end
        check("R5 apply_v1 strobe", apply_v1, 1);
        check("R5 v1 reaches logic", vec_out, v1);
        step();
        check("R5 apply_v1 one cycle", apply_v1, 0);
        v1_ok = 1'b1;
        for (int k = 0; k < N; k++) begin
            scan_in = v2[N-1-k];
            hold_in = k[0];         // R10: toggled, ignored
            start   = (k == 2);     // R9: start while busy ignored
            if (vec_out !== v1) v1_ok = 1'b0;
            step();
        end
        start = 1'b0;
        check("R6 v1 held during v2 load", v1_ok, 1);
        check("R5 apply_v2 strobe", apply_v2, 1);
        check("R7 v2 released", vec_out, v2);
        step();
        check("R5 apply_v2 one cycle", apply_v2, 0);
        got = '0;
        for (int k = 0; k < N; k++) begin
            got[N-1-k] = scan_out;   // R8 order
            step();
        end
        check("R8 unloaded response", got, exp);
        check("R9 done after unload", done, 1);
        check("R9 busy low after unload", busy, 0);
        test_ctl = 1'b1;
        hold_in  = 1'b1;
        step();
        check("R9 done stays high", done, 1);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; test_ctl = 1'b1; hold_in = 1'b1; scan_in = 1'b1;
        step(); step();
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 scan_out", scan_out, 0);
        check("R1 vec_out", vec_out, 0);
        check("R1 strobes", {apply_v1, apply_v2}, 0);
        rst_n = 1'b1;
        step();

        // Table walk
        for (int t = 0; t < 5; t++) begin
            run_pair(TAB[t][23:16], TAB[t][15:8], TAB[t][7:0]);
        end

        // Directed manual scan, hold and capture; pattern C3, response D2
        test_ctl = 1'b1;
        hold_in  = 1'b0;
        step();
        hold_in = 1'b1;             // freeze current value
        step();
        begin
            logic [N-1:0] frozen;
            logic [N-1:0] pat;
            logic [N-1:0] got;
            frozen = vec_out;
            pat = 8'hC3;
            for (int k = 0; k < N; k++) begin
                scan_in = pat[N-1-k];
                step();
            end
            check("R2 scan_out shows cell N-1", scan_out, pat[N-1]);
            check("R4 frozen during shift", vec_out, frozen);
            hold_in = 1'b0;
            #1;
            check("R4 transparent when released", vec_out, pat);
            hold_in = 1'b1;
            test_ctl = 1'b0;
            step();
            test_ctl = 1'b1;
            check("R4 frozen during capture", vec_out, pat);
            got = '0;
            for (int k = 0; k < N; k++) begin
                got[N-1-k] = scan_out;
                step();
            end
            check("R3 parallel capture", got, 8'hD2);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule